// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one read or write command of a double-data-rate memory into the series of column addresses that the burst touches. When a command strobe arrives while the block is idle, it latches three things: the starting column, a three-bit burst-length code and a one-bit burst-type selector. From the next cycle on it presents one column address per clock, with a valid flag, until the burst is over. It raises a last-beat flag on the final address of the burst.

A burst of 2, 4 or 8 beats stays inside a block of columns that is aligned to its own length. The column bits above the in-block offset are held for the whole burst. The in-block offset starts at the low bits of the starting column. In sequential order the offset then counts up and wraps. In interleaved order the offset of beat k is the start offset XOR k.

A length code that does not name a legal length produces a one-cycle error pulse and no beats. A strobe that arrives during a burst is dropped. Reads and writes use the same sequencing.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, beat_valid, beat_last, busy and len_err are all 0 and col_out is 0.
- R2: A strobe accepted while idle with a legal code makes beat_valid 1 in the next cycle, and the first col_out equals the starting column exactly.
- R3: Throughout a burst of length BL, the col_out bits from log2(BL) upward equal the same bits of the starting column.
- R4: With mode_word[3] = 0 (sequential), the in-block offset of beat k is (start + k) mod BL.
- R5: With mode_word[3] = 1 (interleaved), the in-block offset of beat k is start XOR k.
- R6: mode_word[2:0] selects the length: 1 gives 2 beats, 2 gives 4 beats and 3 gives 8 beats. The same length and type apply to every burst.
- R7: beat_last is 1 only on the final beat of the burst, and beat_valid is 0 in the cycle after it.
- R8: A strobe while idle with mode_word[2:0] equal to 0, 4, 5, 6 or 7 raises len_err for exactly one cycle, the cycle after the strobe. No beats follow.
- R9: busy equals beat_valid. A strobe while busy, including one carrying a reserved code, changes neither the running burst nor len_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_col | input | COL_W | Starting column address |
| mode_word | input | 4 | [2:0] length code, [3] interleaved when 1 |
| col_out | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | col_out holds a beat |
| beat_last | output | 1 | Current beat is the last of the burst |
| busy | output | 1 | A burst is in progress |
| len_err | output | 1 | Pulse: the last strobe carried a reserved length code |

## Verification
The properties assume that the length and type latched for a burst stay fixed until the burst ends, and that the sequential step check applies only while beats are valid. The stimulus keeps inputs from disturbing that state by changing them only at falling edges. Any strobe it sends during a burst, including one with a reserved code, falls on a busy cycle, so it tests the drop rule and cannot break those assumptions. Reset is released before the first strobe, and every burst runs to its last beat before the next accepted command.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int OFF_W = 3;

  function automatic logic code_legal(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
  endfunction

  function automatic logic [1:0] code_to_lg(input logic [2:0] code);
    case (code)
      3'd1:    return 2'd1;
      3'd2:    return 2'd2;
      3'd3:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] lg_mask(input logic [1:0] lg);
    case (lg)
      2'd1:    return 3'b001;
      2'd2:    return 3'b011;
      2'd3:    return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] beat_offset(input logic [OFF_W-1:0] start,
                                                   input logic [OFF_W-1:0] k,
                                                   input logic ilv,
                                                   input logic [1:0] lg);
    logic [OFF_W-1:0] raw;
    raw = ilv ? (start ^ k) : (start + k);
    return raw & lg_mask(lg);
  endfunction
endpackage

// File: rtl/bcs_decode.sv
module bcs_decode (
  input  logic [3:0] mode_word,
  output logic [1:0] lg,
  output logic       ilv,
  output logic       legal
);
  import bcs_pkg::*;
  always_comb begin
    lg    = code_to_lg(mode_word[2:0]);
    legal = code_legal(mode_word[2:0]);
    ilv   = mode_word[3];
  end
endmodule

// File: rtl/bcs_counter.sv
module bcs_counter (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic                    reject,
  input  logic [1:0]              lg_in,
  output logic                    active,
  output logic                    is_last,
  output logic                    err,
  output logic [1:0]              cur_lg,
  output logic [bcs_pkg::OFF_W-1:0] beat_idx
);
  import bcs_pkg::*;

  always_comb is_last = active && (beat_idx == lg_mask(cur_lg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      beat_idx <= '0;
      cur_lg   <= 2'd0;
      err      <= 1'b0;
    end else begin
      err <= reject;
      if (accept) begin
        active   <= 1'b1;
        beat_idx <= '0;
        cur_lg   <= lg_in;
      end else if (active) begin
        if (is_last) active <= 1'b0;
        else         beat_idx <= beat_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcs_addr.sv
module bcs_addr #(
  parameter int COL_W = 10
) (
  input  logic                      active,
  input  logic [COL_W-1:0]          base_col,
  input  logic [bcs_pkg::OFF_W-1:0] beat_idx,
  input  logic                      ilv,
  input  logic [1:0]                lg,
  output logic [COL_W-1:0]          col_out
);
  import bcs_pkg::*;
  localparam int HI_W = COL_W - OFF_W;

  logic [COL_W-1:0] keep_mask;
  logic [OFF_W-1:0] off;

  always_comb begin
    keep_mask = ~{{HI_W{1'b0}}, lg_mask(lg)};
    off       = beat_offset(base_col[OFF_W-1:0], beat_idx, ilv, lg);
    col_out   = active ? ((base_col & keep_mask) | {{HI_W{1'b0}}, off}) : '0;
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [3:0]       mode_word,
  output logic [COL_W-1:0] col_out,
  output logic             beat_valid,
  output logic             beat_last,
  output logic             busy,
  output logic             len_err
);
  import bcs_pkg::*;

  logic [1:0]       dec_lg;
  logic             dec_ilv;
  logic             dec_legal;
  logic             accept_w;
  logic             reject_w;
  logic             active_w;
  logic             last_w;
  logic             err_w;
  logic [1:0]       cur_lg;
  logic [OFF_W-1:0] beat_idx;
  logic [COL_W-1:0] col_q;
  logic             cur_ilv;

  bcs_decode dec_i (
    .mode_word(mode_word), .lg(dec_lg), .ilv(dec_ilv), .legal(dec_legal)
  );

  assign accept_w = cmd_valid && !active_w && dec_legal;
  assign reject_w = cmd_valid && !active_w && !dec_legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      cur_ilv <= 1'b0;
    end else if (accept_w) begin
      col_q   <= cmd_col;
      cur_ilv <= dec_ilv;
    end
  end

  bcs_counter cnt_i (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .reject(reject_w),
    .lg_in(dec_lg), .active(active_w), .is_last(last_w), .err(err_w),
    .cur_lg(cur_lg), .beat_idx(beat_idx)
  );

  bcs_addr #(.COL_W(COL_W)) addr_i (
    .active(active_w), .base_col(col_q), .beat_idx(beat_idx),
    .ilv(cur_ilv), .lg(cur_lg), .col_out(col_out)
  );

  assign beat_valid = active_w;
  assign beat_last  = last_w;
  assign busy       = active_w;
  assign len_err    = err_w;
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [COL_W-1:0] col_out,
  input logic             beat_valid,
  input logic             beat_last,
  input logic             busy,
  input logic             len_err,
  input logic [1:0]       cur_lg,
  input logic             cur_ilv
);
  import bcs_pkg::*;

  // R7
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> !beat_valid);

  // R2
  burst_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> beat_valid);

  // R3
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=>
      (col_out[COL_W-1:OFF_W] == $past(col_out[COL_W-1:OFF_W])));

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last && !cur_ilv) |=>
      (((col_out[OFF_W-1:0] - $past(col_out[OFF_W-1:0])) & lg_mask(cur_lg)) == 3'd1));

  // R8
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> !beat_valid);

  // R9
  busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == beat_valid);
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .col_out(col_out), .beat_valid(beat_valid),
  .beat_last(beat_last), .busy(busy), .len_err(len_err),
  .cur_lg(cur_lg), .cur_ilv(cur_ilv)
);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [3:0]       mode_word = 4'd0;
  logic [COL_W-1:0] col_out;
  logic             beat_valid, beat_last, busy, len_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
    .mode_word(mode_word), .col_out(col_out), .beat_valid(beat_valid),
    .beat_last(beat_last), .busy(busy), .len_err(len_err)
  );

  typedef struct packed {
    logic [3:0]  mode;
    logic [9:0]  col;
    logic [3:0]  n;
    logic [23:0] seq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'b0001, 10'h3A5, 4'd2, {18'd0, 3'd0, 3'd1}},
    '{4'b1001, 10'h100, 4'd2, {18'd0, 3'd1, 3'd0}},
    '{4'b0010, 10'h0F5, 4'd4, {12'd0, 3'd0, 3'd3, 3'd2, 3'd1}},
    '{4'b1010, 10'h2B7, 4'd4, {12'd0, 3'd0, 3'd1, 3'd2, 3'd3}},
    '{4'b0011, 10'h156, 4'd8, {3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd7, 3'd6}},
    '{4'b1011, 10'h3FD, 4'd8, {3'd2, 3'd3, 3'd0, 3'd1, 3'd6, 3'd7, 3'd4, 3'd5}},
    '{4'b1011, 10'h00A, 4'd8, {3'd5, 3'd4, 3'd7, 3'd6, 3'd1, 3'd0, 3'd3, 3'd2}},
    '{4'b0011, 10'h3FF, 4'd8, {3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd7}}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Runs one burst. When inj is set, a strobe with other values is sent during beat 2.
  task automatic run_burst(input logic [3:0] mode, input logic [9:0] col,
                           input int n, input logic [23:0] seq, input bit inj);
    logic [9:0] upper;
    string tag;
    upper = col & ~10'(n - 1);
    tag = mode[3] ? "R5" : "R4";
    @(negedge clk);
    mode_word = mode; cmd_col = col; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 first beat valid", 32'(beat_valid), 32'd1);
    chk("R2 first beat is start column", 32'(col_out), 32'(col));
    for (int i = 0; i < n; i++) begin
      chk({tag, " R3 R6 beat address"}, 32'(col_out), 32'(upper | 10'(seq[3*i +: 3])));
      chk("R7 last flag", 32'(beat_last), 32'(i == n - 1));
      chk("R9 busy equals valid", 32'(busy), 32'(beat_valid));
      chk("R9 no error during burst", 32'(len_err), 32'd0);
      if (inj && i == 2) begin
        mode_word = 4'b0111; cmd_col = ~col; cmd_valid = 1'b1;
      end else begin
        cmd_valid = 1'b0;
      end
      if (i < n - 1) @(negedge clk);
    end
    // A strobe at the edge that ends the burst must also be dropped.
    if (inj) begin
      mode_word = 4'b0011; cmd_col = 10'h055; cmd_valid = 1'b1;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7 idle after last", 32'(beat_valid), 32'd0);
    chk("R9 not busy after last", 32'(busy), 32'd0);
    chk("R9 dropped strobe gives no error", 32'(len_err), 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 valid in reset", 32'(beat_valid), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(beat_valid), 32'd0);
    chk("R1 last after reset", 32'(beat_last), 32'd0);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 error after reset", 32'(len_err), 32'd0);
    chk("R1 column after reset", 32'(col_out), 32'd0);

    for (int v = 0; v < 8; v++)
      run_burst(VECS[v].mode, VECS[v].col, int'(VECS[v].n), VECS[v].seq, 1'b0);

    // R9: strobes during a burst are dropped
    run_burst(4'b1011, 10'h1E9, 8, {3'd6, 3'd7, 3'd4, 3'd5, 3'd2, 3'd3, 3'd0, 3'd1}, 1'b1);

    // R8: reserved length codes
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 3) continue;
      @(negedge clk);
      mode_word = {c[0], 3'(c)}; cmd_col = 10'h2A2; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R8 error pulse", 32'(len_err), 32'd1);
      chk("R8 no beat", 32'(beat_valid), 32'd0);
      @(negedge clk);
      chk("R8 error one cycle", 32'(len_err), 32'd0);
      chk("R8 still no beat", 32'(beat_valid), 32'd0);
    end

    // R6: a legal burst right after a reserved code still works
    run_burst(4'b0010, 10'h00E, 4, {12'd0, 3'd1, 3'd0, 3'd3, 3'd2}, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule